// File: doc/BRIEF.md
# Port Condition Change Interrupt Unit

This unit sits in a multiport repeater and watches four status conditions reported for every port: link test state, loopback error, polarity and SQE test error. The port set has twelve numbered ports, an AUI port, a reduced AUI port and an optional expansion port. Each condition of each port is compared against its value from the previous clock. Any difference, whether rising or falling, sets a sticky change flag for that condition and port.

Every condition type has its own 16-bit enable mask and its own 16-bit change flag bank. A flag whose enable bit is set drives one shared, active-high interrupt output. That output is registered. Management software reaches the masks and the flag banks through a byte-wide register port. The masks can be read and written. The flag banks can be read, and a bit is cleared by writing 1 to it. The conditions themselves come from physical-layer logic outside this unit.

Top module: `port_chg_irq`

## Requirements
- R1: After reset, every enable byte and every status byte reads 0x00 and `irq_o` is low.
- R2: When a condition input of one port differs from its value sampled on the previous clock, in either direction, that condition's status bit for that port reads 1 after the next rising edge. No other status bit is set by that change.
- R3: The first sample taken after reset never counts as a change, whatever levels the condition inputs hold.
- R4: A status bit stays 1 until a management write puts 1 in its bit position. Writing 0 to a status bit leaves it unchanged.
- R5: If a clearing write and a new change hit the same status bit on the same clock edge, the bit stays 1. Other bits cleared by that write still go to 0.
- R6: `irq_o` is high exactly one clock after some status bit is 1 while its enable bit is 1. A set status bit whose enable is 0 does not raise `irq_o`.
- R7: Enable byte b (0 or 1) of condition c sits at address 0xE2 + 2c + b, with conditions ordered link = 0, loopback = 1, polarity = 2, SQE = 3. Byte 0 bit k is port k for k = 0..7. Byte 1 bits 0..3 are ports 8..11. Byte 1 bit 7 always reads 0 and cannot be written.
- R8: Status byte b of condition c sits at address 0xF2 + 2c + b and uses the same bit layout as the enables. Writing an enable byte never alters a status bit.
- R9: Byte 1 bit 4 is the AUI port, bit 5 the reduced AUI port and bit 6 the expansion port. When the unit is built without an expansion port, bit 6 reads 0 in both enables and status and never sets.
- R10: Reads from any other address return 0x00, and writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_i | input | 15 | Link test state per port (bit 12 AUI, 13 reduced AUI, 14 expansion) |
| lpbk_i | input | 15 | Loopback error per port |
| pol_i | input | 15 | Polarity state per port |
| sqe_i | input | 15 | SQE test error per port |
| mgmt_wr_i | input | 1 | Write strobe for the register port |
| mgmt_addr_i | input | 8 | Register byte address |
| mgmt_wdata_i | input | 8 | Write data byte |
| mgmt_rdata_o | output | 8 | Read data byte for `mgmt_addr_i`, combinational |
| irq_o | output | 1 | Shared interrupt, active high, registered |

## Verification
A clearing write to a status byte and a fresh condition change on the same port can land on the same clock edge. This is the one place where two functions compete for a bit. The bench first sets one flag. On a single falling edge it then flips that port's condition and issues a clear covering both that bit and a neighbouring set bit. After the edge it reads the status byte and expects the changing bit to stay set and the neighbour to be cleared. The same flip-and-clear sequence is also run with a clear that covers only the changing bit.

// File: rtl/port_chg_irq_pkg.sv
package port_chg_irq_pkg;

    // Condition banks, in address order
    localparam int NUM_COND  = 4;
    // Port lines: 12 numbered, AUI, reduced AUI, expansion
    localparam int NUM_LINES = 15;
    localparam int NUM_NUMBERED = 12;
    // Register image: two bytes per bank
    localparam int REG_W     = 16;
    localparam int BYTES_PER_REG = REG_W / 8;

    localparam int AUI_BIT   = NUM_NUMBERED;
    localparam int RAUI_BIT  = NUM_NUMBERED + 1;
    localparam int EXP_BIT   = NUM_NUMBERED + 2;

    // Bits that exist in a register image for a given build
    function automatic logic [REG_W-1:0] live_mask(input bit has_exp);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < EXP_BIT; i++) begin
            m[i] = 1'b1;
        end
        m[EXP_BIT] = has_exp;
        return m;
    endfunction

endpackage

// File: rtl/pci_edge_detect.sv
module pci_edge_detect #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp_i,
    output logic [W-1:0] chg_o
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic         seeded;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.prev   = smp_i;
        s_d.seeded = 1'b1;
        // Before the first sample is captured there is nothing to compare against
        chg_o      = s_q.seeded ? (smp_i ^ s_q.prev) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/pci_status_bank.sv
module pci_status_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] chg_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);

    typedef struct packed {
        logic [W-1:0] stat;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // A change in the clearing cycle re-sets the bit
        s_d.stat = (s_q.stat & ~clr_i) | chg_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat_o = s_q.stat;

    AST_CHG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_i != '0) |=> ((stat_o & $past(chg_i)) == $past(chg_i))); // R2

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(stat_o) & ~stat_o & ~$past(clr_i)) == '0)); // R4

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((chg_i & clr_i) != '0) |=> ((stat_o & $past(chg_i & clr_i)) == $past(chg_i & clr_i))); // R5

endmodule

// File: rtl/pci_regfile.sv
module pci_regfile #(
    parameter int              NC      = 4,
    parameter int              W       = 16,
    parameter logic [7:0]      EN_BASE = 8'hE2,
    parameter logic [7:0]      ST_BASE = 8'hF2,
    parameter logic [W-1:0]    MASK    = 16'h7FFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [7:0]      addr_i,
    input  logic [7:0]      wdata_i,
    input  logic [NC*W-1:0] stat_i,
    output logic [NC*W-1:0] en_o,
    output logic [NC*W-1:0] clr_o,
    output logic [7:0]      rdata_o
);

    localparam int NB = W / 8;

    typedef struct packed {
        logic [NC*W-1:0] en;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        clr_o   = '0;
        rdata_o = '0;
        for (int c = 0; c < NC; c++) begin
            for (int b = 0; b < NB; b++) begin
                if (addr_i == EN_BASE + 8'(NB * c + b)) begin
                    rdata_o = s_q.en[c*W + b*8 +: 8];
                    if (wr_i) begin
                        s_d.en[c*W + b*8 +: 8] = wdata_i & MASK[b*8 +: 8];
                    end
                end
                if (addr_i == ST_BASE + 8'(NB * c + b)) begin
                    rdata_o = stat_i[c*W + b*8 +: 8];
                    if (wr_i) begin
                        clr_o[c*W + b*8 +: 8] = wdata_i;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en_o = s_q.en;

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(en_o)); // R10

    AST_EN_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o & ~{NC{MASK}}) == '0); // R9

endmodule

// File: rtl/port_chg_irq.sv
module port_chg_irq
    import port_chg_irq_pkg::*;
#(
    parameter bit         HAS_EXP = 1'b1,
    parameter logic [7:0] EN_BASE = 8'hE2,
    parameter logic [7:0] ST_BASE = 8'hF2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] link_i,
    input  logic [NUM_LINES-1:0] lpbk_i,
    input  logic [NUM_LINES-1:0] pol_i,
    input  logic [NUM_LINES-1:0] sqe_i,
    input  logic                 mgmt_wr_i,
    input  logic [7:0]           mgmt_addr_i,
    input  logic [7:0]           mgmt_wdata_i,
    output logic [7:0]           mgmt_rdata_o,
    output logic                 irq_o
);

    localparam logic [REG_W-1:0] MASK = live_mask(HAS_EXP);
    localparam int PAD = REG_W - NUM_LINES;

    logic [NUM_COND*REG_W-1:0] cond_flat;
    logic [NUM_COND*REG_W-1:0] stat_flat;
    logic [NUM_COND*REG_W-1:0] en_flat;
    logic [NUM_COND*REG_W-1:0] clr_flat;

    assign cond_flat = {{PAD{1'b0}}, sqe_i,
                        {PAD{1'b0}}, pol_i,
                        {PAD{1'b0}}, lpbk_i,
                        {PAD{1'b0}}, link_i};

    for (genvar c = 0; c < NUM_COND; c++) begin : g_cond
        logic [REG_W-1:0] chg_raw;

        pci_edge_detect #(.W(REG_W)) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .smp_i (cond_flat[c*REG_W +: REG_W]),
            .chg_o (chg_raw)
        );

        pci_status_bank #(.W(REG_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .chg_i  (chg_raw & MASK),
            .clr_i  (clr_flat[c*REG_W +: REG_W]),
            .stat_o (stat_flat[c*REG_W +: REG_W])
        );
    end

    pci_regfile #(
        .NC      (NUM_COND),
        .W       (REG_W),
        .EN_BASE (EN_BASE),
        .ST_BASE (ST_BASE),
        .MASK    (MASK)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mgmt_wr_i),
        .addr_i  (mgmt_addr_i),
        .wdata_i (mgmt_wdata_i),
        .stat_i  (stat_flat),
        .en_o    (en_flat),
        .clr_o   (clr_flat),
        .rdata_o (mgmt_rdata_o)
    );

    typedef struct packed {
        logic irq;
    } top_t;

    top_t t_d, t_q;

    always_comb begin
        t_d     = t_q;
        t_d.irq = |(stat_flat & en_flat);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign irq_o = t_q.irq;

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_flat & en_flat) != '0) |=> irq_o); // R6

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_flat & en_flat) == '0) |=> !irq_o); // R6

endmodule

// File: tb/port_chg_irq_bench.sv
module port_chg_irq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] cnd [4];
    logic        wr = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata, rdata_nx;
    logic        irq, irq_nx;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    port_chg_irq u_port_chg_irq (
        .clk(clk), .rst_n(rst_n),
        .link_i(cnd[0]), .lpbk_i(cnd[1]), .pol_i(cnd[2]), .sqe_i(cnd[3]),
        .mgmt_wr_i(wr), .mgmt_addr_i(addr), .mgmt_wdata_i(wdata),
        .mgmt_rdata_o(rdata), .irq_o(irq)
    );

    port_chg_irq #(.HAS_EXP(1'b0)) u_noexp (
        .clk(clk), .rst_n(rst_n),
        .link_i(cnd[0]), .lpbk_i(cnd[1]), .pol_i(cnd[2]), .sqe_i(cnd[3]),
        .mgmt_wr_i(wr), .mgmt_addr_i(addr), .mgmt_wdata_i(wdata),
        .mgmt_rdata_o(rdata_nx), .irq_o(irq_nx)
    );

    function automatic logic [7:0] en_a(int c, int b);
        return 8'hE2 + 8'(2 * c + b);
    endfunction

    function automatic logic [7:0] st_a(int c, int b);
        return 8'hF2 + 8'(2 * c + b);
    endfunction

    function automatic logic [7:0] bit_of(int p, int b);
        return (p / 8 == b) ? 8'(1 << (p % 8)) : 8'h00;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr_byte(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a);
        @(negedge clk);
        addr = a;
        #1;
    endtask

    task automatic toggle(int c, int p);
        @(negedge clk);
        cnd[c][p] = ~cnd[c][p];
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R3: nonzero levels held across reset release
        cnd[0] = 15'h5A5A; cnd[1] = 15'h0000; cnd[2] = 15'h7FFF; cnd[3] = 15'h1234;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 / R3 reset state
        check("R1 irq", {7'b0, irq}, 8'h00);
        for (int c = 0; c < 4; c++) begin
            for (int b = 0; b < 2; b++) begin
                rd(en_a(c, b)); check("R1 enable", rdata, 8'h00);
                rd(st_a(c, b)); check("R3 status", rdata, 8'h00);
                check("R3 status noexp", rdata_nx, 8'h00);
            end
        end

        // R2/R4/R9 sweep over every condition and port, enables all off
        for (int c = 0; c < 4; c++) begin
            for (int p = 0; p < 15; p++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    toggle(c, p);
                    for (int b = 0; b < 2; b++) begin
                        rd(st_a(c, b));
                        check("R2 status", rdata, bit_of(p, b));
                        check("R9 noexp status", rdata_nx, (p == 14) ? 8'h00 : bit_of(p, b));
                    end
                    rd(st_a((c + 1) % 4, p / 8));
                    check("R2 other bank", rdata, 8'h00);
                    check("R6 masked irq", {7'b0, irq}, 8'h00);
                    wr_byte(st_a(c, p / 8), 8'h00);
                    rd(st_a(c, p / 8));
                    check("R4 write0 keeps", rdata, bit_of(p, p / 8));
                    wr_byte(st_a(c, p / 8), bit_of(p, p / 8));
                    rd(st_a(c, p / 8));
                    check("R4 write1 clears", rdata, 8'h00);
                end
            end
        end

        // R6 interrupt latency and masking
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 6; k++) begin
                int p;
                p = (k == 0) ? 0 : (k == 1) ? 7 : (k == 2) ? 8 : (k == 3) ? 12 : (k == 4) ? 13 : 14;
                wr_byte(en_a(c, p / 8), bit_of(p, p / 8));
                toggle(c, p);
                check("R6 irq not yet", {7'b0, irq}, 8'h00);
                @(negedge clk);
                check("R6 irq raised", {7'b0, irq}, 8'h01);
                check("R9 noexp irq", {7'b0, irq_nx}, (p == 14) ? 8'h00 : 8'h01);
                wr_byte(en_a(c, p / 8), 8'h00);
                @(negedge clk);
                check("R6 irq masked", {7'b0, irq}, 8'h00);
                rd(st_a(c, p / 8));
                check("R6 status kept", rdata, bit_of(p, p / 8));
                wr_byte(st_a(c, p / 8), 8'hFF);
            end
        end

        // R5 clear colliding with a change
        toggle(1, 2);
        toggle(1, 3);
        @(negedge clk);
        cnd[1][3] = ~cnd[1][3];
        addr = st_a(1, 0); wdata = 8'h0C; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        rd(st_a(1, 0));
        check("R5 change beats clear", rdata, 8'h08);
        @(negedge clk);
        cnd[1][3] = ~cnd[1][3];
        addr = st_a(1, 0); wdata = 8'h08; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        rd(st_a(1, 0));
        check("R5 lone collision", rdata, 8'h08);
        wr_byte(st_a(1, 0), 8'hFF);

        // R7/R8/R9 enable readback and independence from status
        for (int c = 0; c < 4; c++) begin
            for (int b = 0; b < 2; b++) begin
                logic [7:0] d;
                d = 8'hA5 ^ 8'(c * 17 + b * 3) ^ 8'h80;
                wr_byte(en_a(c, b), d | 8'hC0);
                rd(en_a(c, b));
                check("R7 enable readback", rdata, (b == 0) ? (d | 8'hC0) : ((d | 8'hC0) & 8'h7F));
                check("R9 noexp enable", rdata_nx, (b == 0) ? (d | 8'hC0) : ((d | 8'hC0) & 8'h3F));
                rd(st_a(c, b));
                check("R8 status untouched", rdata, 8'h00);
            end
        end
        check("R8 irq quiet", {7'b0, irq}, 8'h00);

        // R10 unmapped addresses
        wr_byte(en_a(0, 0), 8'hFF);
        for (int k = 0; k < 5; k++) begin
            logic [7:0] a;
            a = (k == 0) ? 8'h00 : (k == 1) ? 8'hE1 : (k == 2) ? 8'hEA : (k == 3) ? 8'hF1 : 8'hFA;
            wr_byte(a, 8'hFF);
            rd(a);
            check("R10 unmapped read", rdata, 8'h00);
        end
        rd(en_a(0, 0));
        check("R10 enable intact", rdata, 8'hFF);
        rd(en_a(3, 1));
        check("R10 enable intact hi", rdata, ((8'hA5 ^ 8'(3 * 17 + 3) ^ 8'h80) | 8'hC0) & 8'h7F);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule